// File: doc/BRIEF.md
# Cascadable presettable binary counter

The block is a synchronous up-counter made of 4-bit stages. The stages can be chained to form a wider synchronous counter. All stages share the clock, an active-low reset and an active-low load strobe. The load strobe copies a parallel data word into the state.

Counting needs two active-high enables.

- The parallel enable goes straight to every stage.
- The trickle enable goes to the first stage only. Each later stage takes the terminal count of the stage below it as its trickle enable.
- The trickle enable also gates a stage's terminal count. The parallel enable does not. Because of this, a carry across the chain needs no extra register and no extra clock edge.

A parameter selects the reset variant. In the synchronous variant, reset acts on the next rising edge. In the asynchronous variant, reset clears the state at once.

The top-level terminal count is the carry out of the last stage. It can enable a further chain.

Top module: `cascade_counter`

## Requirements
- R1: Each 4-bit stage counts modulo 16, so a counting edge in state 15 gives state 0.
- R2: When reset is low and the synchronous variant is selected (ASYNC_RST=0), every state bit is zero after the next rising edge. This holds whatever the load and enable inputs are. When the asynchronous variant is selected (ASYNC_RST=1), a low reset clears the state immediately, without a clock edge.
- R3: When reset is high and load_n is low, the next rising edge copies din into q. This holds whatever the enables are.
- R4: When reset and load_n are both high and either enable is low, q holds its value over the edge.
- R5: A stage's terminal count is high exactly when its state is 15 and its trickle enable is high. It is combinational, so a change on the trickle enable reaches it with no clock edge. It does not depend on en_par or load_n.
- R6: When reset and load_n are high and both external enables are high, the whole 4N-bit value q increments by one modulo 2^(4N). The carry crosses stage boundaries in the same edge.
- R7: carry_out is high exactly when all 4N bits of q are one and en_trk is high.
- R8: Reset has priority over load. With reset low and load_n low together, q becomes zero and not din.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the state changes on the rising edge |
| rst_n | input | 1 | Active-low reset; synchronous or asynchronous per ASYNC_RST |
| load_n | input | 1 | Active-low parallel load strobe |
| din | input | 4*STAGES | Parallel load data |
| en_par | input | 1 | Parallel count enable, sent to all stages |
| en_trk | input | 1 | Trickle count enable for stage 0; also gates carry_out |
| q | output | 4*STAGES | Counter state; stage 0 is the low nibble |
| carry_out | output | 1 | Terminal count of the last stage |

## Verification
- A wrong state bit appears on q in the sample taken right after the edge that produced it.
- A wrong bit also stays on q in every following sample, because the state feeds back into its own next value. The reference model in the bench therefore catches it on the first counting, hold or load cycle.
- A broken carry path shows up in two places:
  - the upper nibble fails to step on the edge where the low nibble wraps from 15 to 0;
  - carry_out shows the wrong level while the value is all ones, with no clock edge needed for that check.

// File: rtl/cascade_counter.sv
module cascade_counter_stage #(
  parameter int W = 4,
  parameter bit ASYNC_RST = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_n,
  input  logic [W-1:0] din,
  input  logic         en_par,
  input  logic         en_trk,
  output logic [W-1:0] q,
  output logic         tc
);
  localparam logic [W-1:0] ONE = 1;

  logic [W-1:0] nxt;

  assign nxt = !load_n ? din : (en_par && en_trk) ? q + ONE : q;
  assign tc  = (&q) && en_trk;

  generate
    if (ASYNC_RST) begin : g_async
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end else begin : g_sync
      always_ff @(posedge clk)
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end
  endgenerate

  p_reset_clears_r2: assert property (@(posedge clk) !rst_n |=> q == '0);
  p_reset_over_load_r8: assert property (@(posedge clk) (!rst_n && !load_n) |=> q == '0);
  p_load_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> q == $past(din));
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !(en_par && en_trk)) |=> $stable(q));
  p_count_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && en_par && en_trk) |=> q == $past(q) + ONE);
endmodule

module cascade_counter #(
  parameter int STAGES = 2,
  parameter bit ASYNC_RST = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_n,
  input  logic [4*STAGES-1:0]   din,
  input  logic                  en_par,
  input  logic                  en_trk,
  output logic [4*STAGES-1:0]   q,
  output logic                  carry_out
);
  localparam int N = 4 * STAGES;
  localparam logic [N-1:0] ONE = 1;

  logic [STAGES:0] trk;

  assign trk[0]    = en_trk;
  assign carry_out = trk[STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    cascade_counter_stage #(.W(4), .ASYNC_RST(ASYNC_RST)) u_stage (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_n (load_n),
      .din    (din[4*i +: 4]),
      .en_par (en_par),
      .en_trk (trk[i]),
      .q      (q[4*i +: 4]),
      .tc     (trk[i+1])
    );
  end

  p_chain_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && en_par && en_trk) |=> q == $past(q) + ONE);
  p_chain_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
    carry_out == ((&q) && en_trk));
endmodule

// File: tb/cascade_counter_test.sv
`timescale 1ns/1ps
module cascade_counter_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0, load_n = 1'b1, en_par = 1'b0, en_trk = 1'b0;
  logic [7:0] din = '0;
  logic [7:0] q;
  logic [3:0] qa;
  logic carry_out, carry_a;
  logic [7:0] exp_q;
  int n_tests = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  cascade_counter #(.STAGES(2), .ASYNC_RST(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .din(din),
    .en_par(en_par), .en_trk(en_trk), .q(q), .carry_out(carry_out));

  cascade_counter #(.STAGES(1), .ASYNC_RST(1'b1)) uut_a (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .din(din[3:0]),
    .en_par(en_par), .en_trk(en_trk), .q(qa), .carry_out(carry_a));

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] model(input logic [7:0] cur);
    if (!rst_n) return 8'h00;
    if (!load_n) return din;
    if (en_par && en_trk) return cur + 8'h01;
    return cur;
  endfunction

  task automatic step();
    exp_q = model(exp_q);
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    rst_n = 0; load_n = 1; en_par = 1; en_trk = 1;
    step(); step();
    check("R2 reset q", q, 8'h00);
    check("R2 reset carry", carry_out, 0);
    check("R2 async reset q", qa, 4'h0);
    rst_n = 1;
  endtask

  task automatic t_load();
    load_n = 0; din = 8'hA5; en_par = 1; en_trk = 1;
    step();
    check("R3 load over count", q, 8'hA5);
    din = 8'h3C; en_par = 0; en_trk = 0;
    step();
    check("R3 load enables low", q, 8'h3C);
    load_n = 1;
  endtask

  task automatic t_wrap();
    load_n = 0; din = 8'h0E; step(); load_n = 1;
    en_par = 1; en_trk = 1;
    step(); check("R1 count to 0F", q, 8'h0F);
    step(); check("R1 R6 nibble wrap carries", q, 8'h10);
    step(); check("R6 count after carry", q, 8'h11);
  endtask

  task automatic t_hold();
    en_par = 0; en_trk = 1; step();
    check("R4 hold par low", q, exp_q);
    en_par = 1; en_trk = 0; step();
    check("R4 hold trk low", q, exp_q);
    check("R4 model value", q, 8'h11);
  endtask

  task automatic t_tc();
    load_n = 0; din = 8'h0F; step(); load_n = 1;
    en_par = 0; en_trk = 1; #1;
    check("R7 low nibble ones only", carry_out, 0);
    load_n = 0; din = 8'hFF; step(); load_n = 1;
    en_par = 0; en_trk = 1; #1;
    check("R5 R7 carry with par low", carry_out, 1);
    en_trk = 0; #1;
    check("R5 carry follows trk", carry_out, 0);
    en_trk = 1; load_n = 0; #1;
    check("R5 carry ignores load_n", carry_out, 1);
    load_n = 1; en_par = 1; step();
    check("R6 full wrap", q, 8'h00);
    check("R7 carry after wrap", carry_out, 0);
  endtask

  task automatic t_rst_over_load();
    load_n = 0; din = 8'h77; step();
    check("R3 preload", q, 8'h77);
    rst_n = 0; din = 8'h55; step();
    check("R8 reset over load", q, 8'h00);
    rst_n = 1; load_n = 1;
  endtask

  task automatic t_async();
    load_n = 0; din = 8'h09; step(); load_n = 1; en_par = 0;
    check("R3 async variant load", qa, 4'h9);
    rst_n = 0; #1;
    check("R2 async clears at once", qa, 4'h0);
    check("R2 sync waits for edge", q, 8'h09);
    step();
    check("R2 sync clears on edge", q, 8'h00);
    rst_n = 1;
  endtask

  task automatic t_mixed();
    load_n = 0; din = 8'hF0; step();
    for (int i = 0; i < 80; i++) begin
      en_par = (i % 3) != 0;
      en_trk = (i % 5) != 1;
      load_n = (i % 23) != 7;
      din = 8'(i * 37);
      step();
      check("R6 mixed sequence", q, exp_q);
      check("R7 mixed carry", carry_out, ((exp_q == 8'hFF) && en_trk) ? 1 : 0);
    end
    load_n = 1;
  endtask

  initial begin
    exp_q = 8'h00;
    @(posedge clk); #1;
    t_reset();
    t_load();
    t_wrap();
    t_hold();
    t_tc();
    t_rst_over_load();
    t_async();
    t_mixed();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #50000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule